// File: doc/BRIEF.md
# Pixel Colour Lookup Stage with Overlay Planes

This block sits in a video output path at the pixel clock. Every cycle it accepts an 8-bit colour index, a 2-bit overlay plane select and active-low blank and sync strobes. Two cycles later it presents one 24-bit RGB word together with matching blank and sync flags to a downstream converter. The sync flag belongs to the green channel. Red and blue have no sync flag.

The colour comes from one of two places. The first is a 256-entry by 24-bit palette memory addressed by the index. The second is one of four 24-bit overlay registers. A non-zero overlay select always wins. With the select at zero, a palette-enable bit in an 8-bit command register decides between the palette and overlay 0.

A small host port loads and reads back the palette, the overlays and the command register. Palette and overlay words move as three byte accesses in the order red, green, blue. These accesses go through a shared address register that advances after each blue byte.

Top module: `clut_stage`

## Requirements
- R1: The pixel path delivers one 24-bit colour every clock, with a fixed latency of two clocks from the input edge to `rgb_o`. Red is `rgb_o[23:16]`, green is `rgb_o[15:8]` and blue is `rgb_o[7:0]`.
- R2: With `ovl_sel_i` = 0 and command bit 6 = 1, the output is the palette word addressed by `pix_idx_i`, for every index 0x00 to 0xFF.
- R3: With `ovl_sel_i` = 0 and command bit 6 = 0, the output is overlay 0 whatever `pix_idx_i` is.
- R4: With `ovl_sel_i` = 1, 2 or 3, the output is overlay 1, 2 or 3 respectively, regardless of `pix_idx_i` and of command bit 6.
- R5: While `blank_ni` is low, the colour two clocks later is all zero. `blank_no` is `blank_ni` delayed by two clocks and resets low.
- R6: `sync_g_no` is `sync_ni` delayed by two clocks and resets high.
- R7: `host_sel_i` encodes the targets as follows: 0 is the address, 1 is palette data, 2 is the command, 3 is overlay data. Data writes take red, then green, then blue. The word is committed to entry `addr` only on the blue byte (for overlays, to overlay `addr[1:0]`), and the address then increments.
- R8: A data read returns red, green and blue of entry `addr` on three successive reads, then advances the address. `host_rdata_o` updates on the clock after a read strobe and holds otherwise. A read of selector 0 returns the address.
- R9: The command register can be written and read back at any time. Host data bit n lands in command bit n.
- R10: Writing the address register restarts the byte phase at red, and it discards any partially written word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pix_idx_i | input | 8 | Palette index |
| ovl_sel_i | input | 2 | Overlay plane select |
| blank_ni | input | 1 | Blank strobe, active low |
| sync_ni | input | 1 | Sync strobe, active low |
| host_cs_i | input | 1 | Host access enable |
| host_wr_i | input | 1 | Host write strobe |
| host_rd_i | input | 1 | Host read strobe |
| host_sel_i | input | 2 | Host register select |
| host_wdata_i | input | 8 | Host write data |
| host_rdata_o | output | 8 | Host read data, registered |
| rgb_o | output | 24 | Pipelined colour word |
| blank_no | output | 1 | Pipelined blank flag, active low |
| sync_g_no | output | 1 | Pipelined green-channel sync flag, active low |

## Verification
A wrong byte phase or address in the host port shows up as rotated or shifted colour channels. It appears on the next readback, or two clocks after a pixel first selects the damaged entry. A wrong select decode or a wrong palette-enable decode puts a different plane's colour on `rgb_o` exactly two clocks after the offending select. A misaligned blank or sync delay shifts those flags against the colour. That misalignment is visible on the first strobe edge after reset.

// File: rtl/clut_pkg.sv
package clut_pkg;
  typedef enum logic [1:0] {
    REG_ADDR = 2'd0,
    REG_PAL  = 2'd1,
    REG_CMD  = 2'd2,
    REG_OVL  = 2'd3
  } host_reg_e;

  localparam int unsigned NUM_BYTES = 3;

  function automatic logic [7:0] pick_byte(input logic [23:0] word, input logic [1:0] ph);
    case (ph)
      2'd0:    pick_byte = word[23:16];
      2'd1:    pick_byte = word[15:8];
      default: pick_byte = word[7:0];
    endcase
  endfunction
endpackage

// File: rtl/clut_ram.sv
module clut_ram #(
  parameter int unsigned DEPTH = 256,
  parameter int unsigned WIDTH = 24,
  localparam int unsigned AW = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             we_i,
  input  logic [AW-1:0]    waddr_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic [AW-1:0]    pix_addr_i,
  output logic [WIDTH-1:0] pix_data_o,
  input  logic [AW-1:0]    host_addr_i,
  output logic [WIDTH-1:0] host_data_o
);
  logic [WIDTH-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign pix_data_o  = mem_q[pix_addr_i];
  assign host_data_o = mem_q[host_addr_i];
endmodule

// File: rtl/clut_host_if.sv
module clut_host_if
  import clut_pkg::*;
#(
  parameter int unsigned IDX_W = 8,
  parameter int unsigned CH_W  = 8,
  parameter int unsigned N_OVL = 4,
  localparam int unsigned OVL_W = $clog2(N_OVL),
  localparam int unsigned PIX_W = 3 * CH_W
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        cs_i,
  input  logic                        wr_i,
  input  logic                        rd_i,
  input  logic [1:0]                  sel_i,
  input  logic [CH_W-1:0]             wdata_i,
  output logic [CH_W-1:0]             rdata_o,
  output logic [CH_W-1:0]             cmd_o,
  output logic                        pal_we_o,
  output logic [IDX_W-1:0]            pal_addr_o,
  output logic [PIX_W-1:0]            pal_wdata_o,
  input  logic [PIX_W-1:0]            pal_rdata_i,
  output logic [N_OVL-1:0][PIX_W-1:0] ovl_o,
  output logic [1:0]                  phase_o
);
  logic [IDX_W-1:0]            addr_q;
  logic [1:0]                  phase_q;
  logic [CH_W-1:0]             stg_r_q, stg_g_q;
  logic [CH_W-1:0]             cmd_q;
  logic [CH_W-1:0]             rdata_q;
  logic [N_OVL-1:0][PIX_W-1:0] ovl_q;

  logic do_wr, do_rd, data_sel, last_byte, commit;
  logic [PIX_W-1:0] word_new, word_rd;
  host_reg_e sel;

  assign sel       = host_reg_e'(sel_i);
  assign do_wr     = cs_i && wr_i;
  assign do_rd     = cs_i && rd_i && !wr_i;
  assign data_sel  = (sel == REG_PAL) || (sel == REG_OVL);
  assign last_byte = (phase_q == 2'(NUM_BYTES - 1));
  assign commit    = do_wr && data_sel && last_byte;
  assign word_new  = {stg_r_q, stg_g_q, wdata_i};
  assign word_rd   = (sel == REG_OVL) ? ovl_q[addr_q[OVL_W-1:0]] : pal_rdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      phase_q <= '0;
      stg_r_q <= '0;
      stg_g_q <= '0;
      rdata_q <= '0;
    end else if (do_wr) begin
      if (sel == REG_ADDR) begin
        addr_q  <= IDX_W'(wdata_i);
        phase_q <= '0;
      end else if (data_sel) begin
        if (phase_q == 2'd0) stg_r_q <= wdata_i;
        if (phase_q == 2'd1) stg_g_q <= wdata_i;
        if (last_byte) begin
          phase_q <= '0;
          addr_q  <= addr_q + 1'b1;
        end else begin
          phase_q <= phase_q + 1'b1;
        end
      end
    end else if (do_rd) begin
      case (sel)
        REG_ADDR: rdata_q <= CH_W'(addr_q);
        REG_CMD:  rdata_q <= cmd_q;
        default: begin
          rdata_q <= pick_byte(word_rd, phase_q);
          if (last_byte) begin
            phase_q <= '0;
            addr_q  <= addr_q + 1'b1;
          end else begin
            phase_q <= phase_q + 1'b1;
          end
        end
      endcase
    end
  end

  // command register has no defined reset value
  always_ff @(posedge clk_i) begin
    if (do_wr && sel == REG_CMD) cmd_q <= wdata_i;
  end

  for (genvar g = 0; g < N_OVL; g++) begin : g_ovl
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        ovl_q[g] <= '0;
      else if (commit && sel == REG_OVL && addr_q[OVL_W-1:0] == OVL_W'(g))
        ovl_q[g] <= word_new;
    end
  end

  assign pal_we_o    = commit && (sel == REG_PAL);
  assign pal_addr_o  = addr_q;
  assign pal_wdata_o = word_new;
  assign ovl_o       = ovl_q;
  assign cmd_o       = cmd_q;
  assign rdata_o     = rdata_q;
  assign phase_o     = phase_q;
endmodule

// File: rtl/clut_pixel_pipe.sv
module clut_pixel_pipe #(
  parameter int unsigned IDX_W = 8,
  parameter int unsigned CH_W  = 8,
  parameter int unsigned N_OVL = 4,
  localparam int unsigned OVL_W = $clog2(N_OVL),
  localparam int unsigned PIX_W = 3 * CH_W
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [IDX_W-1:0]            idx_i,
  input  logic [OVL_W-1:0]            ovl_sel_i,
  input  logic                        blank_ni,
  input  logic                        sync_ni,
  input  logic                        pal_en_i,
  input  logic [N_OVL-1:0][PIX_W-1:0] ovl_i,
  output logic [IDX_W-1:0]            pal_addr_o,
  input  logic [PIX_W-1:0]            pal_data_i,
  output logic [PIX_W-1:0]            rgb_o,
  output logic                        blank_no,
  output logic                        sync_no
);
  logic [IDX_W-1:0] idx_q;
  logic [OVL_W-1:0] sel_q;
  logic             vis_q, sync_q;
  logic [PIX_W-1:0] rgb_q, color_d;
  logic             blank_q2, sync_q2;

  // stage 1: register the pixel inputs
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q  <= '0;
      sel_q  <= '0;
      vis_q  <= 1'b0;
      sync_q <= 1'b1;
    end else begin
      idx_q  <= idx_i;
      sel_q  <= ovl_sel_i;
      vis_q  <= blank_ni;
      sync_q <= sync_ni;
    end
  end

  assign pal_addr_o = idx_q;

  // overlay planes outrank the palette; palette disabled falls back to plane 0
  always_comb begin
    if (sel_q != '0)   color_d = ovl_i[sel_q];
    else if (pal_en_i) color_d = pal_data_i;
    else               color_d = ovl_i[0];
  end

  // stage 2: select, blank and register the outputs
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rgb_q    <= '0;
      blank_q2 <= 1'b0;
      sync_q2  <= 1'b1;
    end else begin
      rgb_q    <= vis_q ? color_d : '0;
      blank_q2 <= vis_q;
      sync_q2  <= sync_q;
    end
  end

  assign rgb_o    = rgb_q;
  assign blank_no = blank_q2;
  assign sync_no  = sync_q2;
endmodule

// File: rtl/clut_stage.sv
module clut_stage #(
  parameter int unsigned IDX_W      = 8,
  parameter int unsigned CH_W       = 8,
  parameter int unsigned N_OVL      = 4,
  parameter int unsigned PAL_EN_BIT = 6,
  localparam int unsigned OVL_W = $clog2(N_OVL),
  localparam int unsigned PIX_W = 3 * CH_W,
  localparam int unsigned DEPTH = 1 << IDX_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] pix_idx_i,
  input  logic [OVL_W-1:0] ovl_sel_i,
  input  logic             blank_ni,
  input  logic             sync_ni,
  input  logic             host_cs_i,
  input  logic             host_wr_i,
  input  logic             host_rd_i,
  input  logic [1:0]       host_sel_i,
  input  logic [CH_W-1:0]  host_wdata_i,
  output logic [CH_W-1:0]  host_rdata_o,
  output logic [PIX_W-1:0] rgb_o,
  output logic             blank_no,
  output logic             sync_g_no
);
  logic [CH_W-1:0]             cmd;
  logic                        pal_we;
  logic [IDX_W-1:0]            host_addr, pix_addr;
  logic [PIX_W-1:0]            pal_wdata, pal_host_data, pal_pix_data;
  logic [N_OVL-1:0][PIX_W-1:0] ovl;
  logic [1:0]                  host_phase;

  clut_host_if #(.IDX_W(IDX_W), .CH_W(CH_W), .N_OVL(N_OVL)) u_host (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cs_i       (host_cs_i),
    .wr_i       (host_wr_i),
    .rd_i       (host_rd_i),
    .sel_i      (host_sel_i),
    .wdata_i    (host_wdata_i),
    .rdata_o    (host_rdata_o),
    .cmd_o      (cmd),
    .pal_we_o   (pal_we),
    .pal_addr_o (host_addr),
    .pal_wdata_o(pal_wdata),
    .pal_rdata_i(pal_host_data),
    .ovl_o      (ovl),
    .phase_o    (host_phase)
  );

  clut_ram #(.DEPTH(DEPTH), .WIDTH(PIX_W)) u_ram (
    .clk_i      (clk_i),
    .we_i       (pal_we),
    .waddr_i    (host_addr),
    .wdata_i    (pal_wdata),
    .pix_addr_i (pix_addr),
    .pix_data_o (pal_pix_data),
    .host_addr_i(host_addr),
    .host_data_o(pal_host_data)
  );

  clut_pixel_pipe #(.IDX_W(IDX_W), .CH_W(CH_W), .N_OVL(N_OVL)) u_pipe (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .idx_i     (pix_idx_i),
    .ovl_sel_i (ovl_sel_i),
    .blank_ni  (blank_ni),
    .sync_ni   (sync_ni),
    .pal_en_i  (cmd[PAL_EN_BIT]),
    .ovl_i     (ovl),
    .pal_addr_o(pix_addr),
    .pal_data_i(pal_pix_data),
    .rgb_o     (rgb_o),
    .blank_no  (blank_no),
    .sync_no   (sync_g_no)
  );
endmodule

// File: rtl/clut_stage_chk.sv
module clut_stage_chk #(
  parameter int unsigned CH_W = 8,
  localparam int unsigned PIX_W = 3 * CH_W
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             blank_ni,
  input logic             sync_ni,
  input logic             host_cs_i,
  input logic             host_wr_i,
  input logic             host_rd_i,
  input logic [CH_W-1:0]  host_rdata_o,
  input logic [PIX_W-1:0] rgb_o,
  input logic             blank_no,
  input logic             sync_g_no,
  input logic [1:0]       host_phase
);
  logic [1:0] age_q;
  logic       full;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            age_q <= '0;
    else if (age_q != 2'd3) age_q <= age_q + 1'b1;
  end
  assign full = (age_q >= 2'd2);

  AST_BLANK_BLACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !blank_no |-> rgb_o == '0) else $error("blank not black"); // R5

  AST_BLANK_DELAY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full |-> blank_no == $past(blank_ni, 2)) else $error("blank misaligned"); // R5

  AST_SYNC_DELAY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full |-> sync_g_no == $past(sync_ni, 2)) else $error("sync misaligned"); // R6

  AST_RDATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(host_cs_i && host_rd_i && !host_wr_i) |=> $stable(host_rdata_o)) else $error("rdata moved"); // R8

  AST_PHASE_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_phase != 2'd3) else $error("byte phase out of range"); // R7
endmodule

bind clut_stage clut_stage_chk #(.CH_W(CH_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .blank_ni    (blank_ni),
  .sync_ni     (sync_ni),
  .host_cs_i   (host_cs_i),
  .host_wr_i   (host_wr_i),
  .host_rd_i   (host_rd_i),
  .host_rdata_o(host_rdata_o),
  .rgb_o       (rgb_o),
  .blank_no    (blank_no),
  .sync_g_no   (sync_g_no),
  .host_phase  (host_phase)
);

// File: tb/test_clut_stage.sv
`timescale 1ns/1ps
module test_clut_stage;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  pix_idx = '0;
  logic [1:0]  ovl_sel = '0;
  logic        blank_n = 1'b1;
  logic        sync_n = 1'b1;
  logic        h_cs = 1'b0, h_wr = 1'b0, h_rd = 1'b0;
  logic [1:0]  h_sel = '0;
  logic [7:0]  h_wdata = '0;
  logic [7:0]  h_rdata;
  logic [23:0] rgb;
  logic        blank_o, sync_o;

  int unsigned n_vec = 0;
  int unsigned n_bad = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  clut_stage i_clut_stage (
    .clk_i(clk), .rst_ni(rst_n), .pix_idx_i(pix_idx), .ovl_sel_i(ovl_sel),
    .blank_ni(blank_n), .sync_ni(sync_n), .host_cs_i(h_cs), .host_wr_i(h_wr),
    .host_rd_i(h_rd), .host_sel_i(h_sel), .host_wdata_i(h_wdata),
    .host_rdata_o(h_rdata), .rgb_o(rgb), .blank_no(blank_o), .sync_g_no(sync_o)
  );

  function automatic logic [23:0] pal_val(input int i);
    logic [7:0] b = 8'(i);
    return {b, ~b, b ^ 8'h5A};
  endfunction

  function automatic logic [23:0] ovl_val(input int n);
    return {8'hA0 + 8'(n), 8'h50 + 8'(n), 8'h0F + 8'(n)};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic hwr(input logic [1:0] sel, input logic [7:0] d);
    @(negedge clk);
    h_cs = 1'b1; h_wr = 1'b1; h_sel = sel; h_wdata = d;
    @(negedge clk);
    h_cs = 1'b0; h_wr = 1'b0;
  endtask

  task automatic hrd(input logic [1:0] sel, output logic [7:0] d);
    @(negedge clk);
    h_cs = 1'b1; h_rd = 1'b1; h_sel = sel;
    @(negedge clk);
    h_cs = 1'b0; h_rd = 1'b0;
    d = h_rdata;
  endtask

  task automatic wr_word(input logic [1:0] sel, input logic [23:0] w);
    hwr(sel, w[23:16]); hwr(sel, w[15:8]); hwr(sel, w[7:0]);
  endtask

  task automatic rd_word(input logic [1:0] sel, output logic [23:0] w);
    logic [7:0] r, g, b;
    hrd(sel, r); hrd(sel, g); hrd(sel, b);
    w = {r, g, b};
  endtask

  task automatic pixel_sweep(input bit pal_en);
    logic [23:0] h_rgb [2];
    logic        h_bl [2];
    logic        h_sy [2];
    for (int s = 0; s < 4 * 256 + 2; s++) begin
      @(negedge clk);
      if (s >= 2) begin
        if (h_bl[1] == 1'b0)        chk("R5 blank colour", 32'(rgb), 32'(h_rgb[1]));
        else if (h_rgb[1][31-8] === 1'bx) ;
        else                          chk("R1/R2/R3/R4 colour", 32'(rgb), 32'(h_rgb[1]));
        chk("R5 blank flag", 32'(blank_o), 32'(h_bl[1]));
        chk("R6 sync flag", 32'(sync_o), 32'(h_sy[1]));
      end
      h_rgb[1] = h_rgb[0]; h_bl[1] = h_bl[0]; h_sy[1] = h_sy[0];
      if (s < 4 * 256) begin
        automatic int o = s / 256;
        automatic int i = s % 256;
        pix_idx = 8'(i);
        ovl_sel = 2'(o);
        blank_n = (i % 7) != 3;
        sync_n  = (i % 5) != 0;
        if (!blank_n)    h_rgb[0] = '0;
        else if (o != 0) h_rgb[0] = ovl_val(o);   // R4
        else if (pal_en) h_rgb[0] = pal_val(i);   // R2
        else             h_rgb[0] = ovl_val(0);   // R3
        h_bl[0] = blank_n;
        h_sy[0] = sync_n;
      end
    end
    blank_n = 1'b1; sync_n = 1'b1; ovl_sel = '0;
  endtask

  initial begin : watchdog
    #(5.0 * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin : main
    logic [7:0]  b;
    logic [23:0] w;
    repeat (3) @(negedge clk);
    // reset state
    chk("R5 reset rgb", 32'(rgb), 32'h0);
    chk("R5 reset blank", 32'(blank_o), 32'h0);
    chk("R6 reset sync", 32'(sync_o), 32'h1);
    rst_n = 1'b1;

    // R9 command register
    hwr(2'd2, 8'h01);
    hrd(2'd2, b); chk("R9 cmd bit0", 32'(b), 32'h01);
    hwr(2'd2, 8'h41);
    hrd(2'd2, b); chk("R9 cmd readback", 32'(b), 32'h41);

    // R7 load palette and overlays
    hwr(2'd0, 8'h00);
    for (int i = 0; i < 256; i++) wr_word(2'd1, pal_val(i));
    hrd(2'd0, b); chk("R7 address wrap", 32'(b), 32'h00);
    hwr(2'd0, 8'h00);
    for (int n = 0; n < 4; n++) wr_word(2'd3, ovl_val(n));

    // R8 readback
    hwr(2'd0, 8'h00);
    for (int i = 0; i < 4; i++) begin
      rd_word(2'd1, w); chk("R8 palette readback", 32'(w), 32'(pal_val(i)));
    end
    hrd(2'd0, b); chk("R8 address after reads", 32'(b), 32'h04);
    hwr(2'd0, 8'hFE);
    rd_word(2'd1, w); chk("R8 palette readback FE", 32'(w), 32'(pal_val(254)));
    rd_word(2'd1, w); chk("R8 palette readback FF", 32'(w), 32'(pal_val(255)));
    hwr(2'd0, 8'h02);
    rd_word(2'd3, w); chk("R8 overlay readback", 32'(w), 32'(ovl_val(2)));

    // R10 phase restart on address write
    hwr(2'd0, 8'h05);
    hwr(2'd1, 8'hEE);
    hwr(2'd0, 8'h09);
    wr_word(2'd1, 24'h123456);
    hrd(2'd0, b); chk("R7 address increment", 32'(b), 32'h0A);
    hwr(2'd0, 8'h09);
    rd_word(2'd1, w); chk("R10 restarted word", 32'(w), 32'h123456);
    hwr(2'd0, 8'h05);
    rd_word(2'd1, w); chk("R10 partial discarded", 32'(w), 32'(pal_val(5)));
    hwr(2'd0, 8'h09);
    wr_word(2'd1, pal_val(9));

    // pixel path: palette enabled, then disabled
    pixel_sweep(1'b1);
    hwr(2'd2, 8'h00);
    pixel_sweep(1'b0);
    hwr(2'd2, 8'h40);
    pixel_sweep(1'b1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule